// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port

An eight-pin general-purpose I/O port controlled through a small register bus. Every pin is configured on its own by one bit in each register. A direction bit turns the pad driver on. An output bit gives the level the pin drives. A function-select bit hands the driven level over to an alternate peripheral signal. An input register returns the synchronized pin levels at all times, whatever the direction setting.

Interrupt-capable instances add three registers, with one bit per pin in each: an enable, an edge polarity and a pending flag. A pin's flag is set by the edge that its polarity bit selects, whether or not that pin is enabled. The interrupt request is the OR over all pins of flag AND enable. Software clears a flag by writing 0 to it, and it can raise an interrupt by writing 1. The `IRQ_EN` parameter set to 0 builds a port without any of the three interrupt registers.

The bus writes on a clock edge when `bus_req_i` and `bus_we_i` are both high. Read data is a combinational decode of `bus_addr_i`. Software sets, clears or toggles single output bits by reading the output register, modifying the value and writing it back.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads 0, `pin_oe_o` and `pin_out_o` are 0, and `irq_o` is low.
- R2: `pin_oe_o[i]` equals direction bit i. When select bit i is 0, `pin_out_o[i]` equals output bit i. Writing a new output value changes `pin_out_o` after the write edge and leaves every other bit unchanged.
- R3: When select bit i is 1, `pin_out_o[i]` follows `alt_out_i[i]` whatever output bit i holds. Direction bit i still drives `pin_oe_o[i]`.
- R4: Address 0 reads `pin_in_i` after a two-flop synchronizer, so a pin change is visible after the second rising edge, for any direction setting. Writes to address 0 have no effect.
- R5: Register addresses are 0 input, 1 output, 2 direction, 3 select, 4 interrupt enable, 5 edge polarity and 6 flag. Each writable register reads back what was written, and address 7 reads 0.
- R6: With edge polarity bit 0, a synchronized low-to-high transition sets flag bit i. With polarity bit 1, a high-to-low transition sets it. The flag becomes visible on the third rising edge after the pin changes. It is set even when the enable bit is 0, and a transition of the other polarity leaves it unchanged.
- R7: `irq_o` is high exactly when some pin has both its flag bit and its enable bit set.
- R8: A flag write stores the written value: 0 clears the bit and 1 sets it, which is a software interrupt. When a flag write and a detected edge on the same pin share a clock edge, the flag ends up set.
- R9: With `IRQ_EN` = 0, addresses 4 to 6 read 0, writes to them have no effect, and `irq_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write enable, qualified by bus_req_i |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from bus_addr_i |
| pin_in_i | input | 8 | Pad input levels, asynchronous |
| alt_out_i | input | 8 | Alternate peripheral output levels |
| pin_out_o | output | 8 | Pad output levels |
| pin_oe_o | output | 8 | Pad output enables |
| irq_o | output | 1 | Interrupt request |

## Verification
The flag assertions assume that a pin change reaches the edge detector only through the synchronizer. They also assume that the bus never writes a flag and another register in the same cycle, which a single-address bus already guarantees. The bench changes the pins and the bus inputs only on falling clock edges, and holds every pin level for at least three rising edges before it checks a flag. The synchronizer assertion ignores the first two cycles after reset, while its stages still hold reset values. The bench holds the pins at 0 through reset, so no edge is detected when reset is released.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_IN   = 3'd0,
    RA_OUT  = 3'd1,
    RA_DIR  = 3'd2,
    RA_SEL  = 3'd3,
    RA_IE   = 3'd4,
    RA_EDGE = 3'd5,
    RA_FLAG = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] armed_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          armed_q <= '0;
      else if (!armed_q[1]) armed_q <= armed_q + 2'd1;
    end
    // R4: two-cycle latency from pad to input register
    p_sync_lag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q[1] |-> sync_o == $past(pin_i, 2));
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic         ie_we_i,
  input  logic         edge_we_i,
  input  logic         flag_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ie_o,
  output logic [W-1:0] edge_o,
  output logic [W-1:0] flag_o,
  output logic         irq_o
);
  logic [W-1:0] ie_q, edge_q, flag_q, prev_q, hit;

  // edge_q bit: 0 = rising, 1 = falling
  assign hit = (sync_i & ~prev_q & ~edge_q) | (~sync_i & prev_q & edge_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= '0;
      edge_q <= '0;
      flag_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= sync_i;
      if (ie_we_i)   ie_q   <= wdata_i;
      if (edge_we_i) edge_q <= wdata_i;
      // detected edge wins over a same-cycle clear
      flag_q <= (flag_we_i ? wdata_i : flag_q) | hit;
    end
  end

  assign ie_o   = ie_q;
  assign edge_o = edge_q;
  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & ie_q);

  p_flag_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_we_i && sync_i == prev_q) |=> flag_o == $past(flag_o));
  p_flag_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_i && sync_i == prev_q) |=> flag_o == $past(wdata_i));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] out_i,
  input  logic [W-1:0] sel_i,
  input  logic [W-1:0] alt_i,
  output logic [W-1:0] pin_out_o,
  output logic [W-1:0] pin_oe_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pin_out_o[i] = sel_i[i] ? alt_i[i] : out_i[i];
    assign pin_oe_o[i]  = dir_i[i];
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter bit          IRQ_EN      = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [W-1:0]      bus_wdata_i,
  output logic [W-1:0]      bus_rdata_o,
  input  logic [W-1:0]      pin_in_i,
  input  logic [W-1:0]      alt_out_i,
  output logic [W-1:0]      pin_out_o,
  output logic [W-1:0]      pin_oe_o,
  output logic              irq_o
);
  logic [W-1:0] out_q, dir_q, sel_q, sync_in;
  logic [W-1:0] ie_v, edge_v, flag_v;
  logic         wr;

  assign wr = bus_req_i & bus_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
      sel_q <= '0;
    end else if (wr) begin
      case (bus_addr_i)
        RA_OUT:  out_q <= bus_wdata_i;
        RA_DIR:  dir_q <= bus_wdata_i;
        RA_SEL:  sel_q <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_in_i),
    .sync_o (sync_in)
  );

  if (IRQ_EN) begin : g_irq
    gpio_irq #(.W(W)) u_irq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sync_i    (sync_in),
      .ie_we_i   (wr && bus_addr_i == RA_IE),
      .edge_we_i (wr && bus_addr_i == RA_EDGE),
      .flag_we_i (wr && bus_addr_i == RA_FLAG),
      .wdata_i   (bus_wdata_i),
      .ie_o      (ie_v),
      .edge_o    (edge_v),
      .flag_o    (flag_v),
      .irq_o     (irq_o)
    );
  end else begin : g_no_irq
    assign ie_v   = '0;
    assign edge_v = '0;
    assign flag_v = '0;
    assign irq_o  = 1'b0;
  end

  gpio_pad_mux #(.W(W)) u_mux (
    .dir_i     (dir_q),
    .out_i     (out_q),
    .sel_i     (sel_q),
    .alt_i     (alt_out_i),
    .pin_out_o (pin_out_o),
    .pin_oe_o  (pin_oe_o)
  );

  always_comb begin
    case (bus_addr_i)
      RA_IN:   bus_rdata_o = sync_in;
      RA_OUT:  bus_rdata_o = out_q;
      RA_DIR:  bus_rdata_o = dir_q;
      RA_SEL:  bus_rdata_o = sel_q;
      RA_IE:   bus_rdata_o = ie_v;
      RA_EDGE: bus_rdata_o = edge_v;
      RA_FLAG: bus_rdata_o = flag_v;
      default: bus_rdata_o = '0;
    endcase
  end

  p_oe_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_oe_o == dir_q);
  p_gpio_out_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_out_o ^ out_q) & ~sel_q) == '0);
  p_alt_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_out_o ^ alt_out_i) & sel_q) == '0);
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, pins = '0, alt = '0;
  logic [7:0] rdata, rdata1, pout, poe, pout1, poe1;
  logic       irq, irq1;
  int         vec_n = 0, err_n = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  gpio_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pin_in_i(pins), .alt_out_i(alt), .pin_out_o(pout), .pin_oe_o(poe),
    .irq_o(irq));

  gpio_port #(.IRQ_EN(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata1),
    .pin_in_i(pins), .alt_out_i(alt), .pin_out_o(pout1), .pin_oe_o(poe1),
    .irq_o(irq1));

  typedef struct packed {
    logic [2:0] a;
    logic [7:0] d;
    logic [7:0] alt;
    logic [7:0] exp_out;
    logic [7:0] exp_oe;
    logic [7:0] exp_rd;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{3'd2, 8'h0F, 8'h00, 8'h00, 8'h0F, 8'h0F},  // R2 dir
    '{3'd1, 8'hA5, 8'h00, 8'hA5, 8'h0F, 8'hA5},  // R2 out
    '{3'd1, 8'hA4, 8'h00, 8'hA4, 8'h0F, 8'hA4},  // R2 toggle bit0
    '{3'd3, 8'hF0, 8'h3C, 8'h34, 8'h0F, 8'hF0},  // R3 alt on upper nibble
    '{3'd3, 8'hF0, 8'hC3, 8'hC4, 8'h0F, 8'hF0},  // R3 alt follows input
    '{3'd2, 8'hFF, 8'hC3, 8'hC4, 8'hFF, 8'hFF},  // R3 dir still drives oe
    '{3'd3, 8'h00, 8'hC3, 8'hA4, 8'hFF, 8'h00},  // R2 back to gpio
    '{3'd0, 8'hFF, 8'hC3, 8'hA4, 8'hFF, 8'h00},  // R4 write to input ignored
    '{3'd2, 8'h00, 8'hC3, 8'hA4, 8'h00, 8'h00}   // R2 all inputs
  };

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    vec_n++;
    if (act !== exp) begin
      err_n++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d0, output logic [7:0] d1);
    addr = a; we = 1'b0;
    #1;
    d0 = rdata; d1 = rdata1;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] r0, r1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out", pout, 8'h00);
    chk("R1 oe", poe, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), r0, r1);
      chk("R1 regs", r0, 8'h00);
    end

    for (int i = 0; i < NV; i++) begin
      alt = VT[i].alt;
      wr(VT[i].a, VT[i].d);
      chk("R2/R3 pin_out", pout, VT[i].exp_out);
      chk("R2/R3 pin_oe", poe, VT[i].exp_oe);
      rd(VT[i].a, r0, r1);
      chk("R5 readback", r0, VT[i].exp_rd);
    end

    // R4 synchronizer latency and direction independence
    @(negedge clk) pins = 8'h5A;
    @(posedge clk); @(negedge clk);
    rd(3'd0, r0, r1);
    chk("R4 not yet", r0, 8'h00);
    @(posedge clk); @(negedge clk);
    rd(3'd0, r0, r1);
    chk("R4 input", r0, 8'h5A);
    wr(3'd2, 8'hFF);
    @(negedge clk) pins = 8'h81;
    settle();
    rd(3'd0, r0, r1);
    chk("R4 input as output", r0, 8'h81);
    wr(3'd2, 8'h00);
    rd(3'd7, r0, r1);
    chk("R5 addr7", r0, 8'h00);

    // R6/R7 edges
    @(negedge clk) pins = 8'h00;
    settle();
    wr(3'd6, 8'h00);
    @(negedge clk) pins = 8'h01;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(3'd6, r0, r1);
    chk("R6 flag not early", r0, 8'h00);
    @(posedge clk); @(negedge clk);
    rd(3'd6, r0, r1);
    chk("R6 rising sets flag w/o enable", r0, 8'h01);
    chk("R7 irq masked", {7'd0, irq}, 8'h00);
    wr(3'd4, 8'h01);
    chk("R7 irq enabled", {7'd0, irq}, 8'h01);
    wr(3'd5, 8'h02);
    @(negedge clk) pins = 8'h03;
    settle();
    rd(3'd6, r0, r1);
    chk("R6 rise ignored on falling pin", r0, 8'h01);
    @(negedge clk) pins = 8'h01;
    settle();
    rd(3'd6, r0, r1);
    chk("R6 falling sets flag", r0, 8'h03);
    wr(3'd6, 8'h01);
    rd(3'd6, r0, r1);
    chk("R8 clear one bit", r0, 8'h01);
    wr(3'd6, 8'h00);
    chk("R7 irq low after clear", {7'd0, irq}, 8'h00);
    wr(3'd6, 8'h80);
    rd(3'd6, r0, r1);
    chk("R8 software set", r0, 8'h80);
    chk("R7 irq masked bit7", {7'd0, irq}, 8'h00);
    wr(3'd4, 8'h81);
    chk("R7 irq bit7", {7'd0, irq}, 8'h01);
    wr(3'd6, 8'h00);

    // R8 edge wins over same-cycle clear
    @(negedge clk) pins = 8'h05;
    @(posedge clk); @(posedge clk);
    wr(3'd6, 8'h00);
    rd(3'd6, r0, r1);
    chk("R8 edge beats clear", r0, 8'h04);

    // R9 no-interrupt variant
    wr(3'd4, 8'hFF);
    wr(3'd5, 8'hFF);
    wr(3'd6, 8'hFF);
    chk("R7 irq u0", {7'd0, irq}, 8'h01);
    chk("R9 irq absent", {7'd0, irq1}, 8'h00);
    for (int a = 4; a < 7; a++) begin
      rd(3'(a), r0, r1);
      chk("R9 regs absent", r1, 8'h00);
    end
    rd(3'd0, r0, r1);
    chk("R9 input still works", r1, 8'h05);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      err_n++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
      $finish;
    end
  end
endmodule